// File: doc/BRIEF.md
# Prioritizing External Interrupt Encoder

This block gathers interrupt requests from five external pins and from a vector of internal sources. It holds each request in a pending latch and shows the processor the highest pending level as a 4-bit code. Code zero means idle. Code fifteen is the non-maskable level, and codes one to fourteen are maskable levels. When the processor acknowledges, the pending latch of the level currently shown is cleared. Reading the level has no side effect.

Each external pin is resynchronised through two flops. A configuration register chooses, per pin, whether the pin is edge or level sensitive and whether it is active high or active low. A separate acknowledge pulse can be sent back to the device behind one chosen external pin. It fires only when the processor acknowledges that pin's level. Configuration is loaded through a plain register write port.

Top module: `irq_prio_enc`

## Requirements
- R1: While reset is held and right after it, `lvl_o` is 0 and `ext_ack_o` is 0. All inputs start in level mode and active high, and the acknowledge route selects input 0.
- R2: `lvl_o` shows the highest-numbered pending level, or 0 when nothing is pending. It changes one clock after the pending set changes. An `int_req_i` pulse sampled at edge N appears on `lvl_o` after edge N+1.
- R3: Bit `l-1` of `int_req_i` requests level `l`. Level 15 (bit 14) is the non-maskable code 4'b1111 and outranks every other pending level.
- R4: External input k requests level 2+k (`EXT_BASE`=2). A change on `ext_irq_i` sampled at edge N reaches `lvl_o` after edge N+3 and not earlier.
- R5: In edge mode, a pin sets its pending latch only on an active transition. Holding the pin active after the acknowledge does not set the latch again.
- R6: In level mode, a pin sets its pending latch on every cycle that it is active. An acknowledge given while the pin stays active leaves that level shown. Once the pin goes inactive, an acknowledge clears the level.
- R7: With the polarity bit of a pin set, the pin is active low: a falling transition is the active edge, and low is the active level.
- R8: When `ack_i` is high at an edge, only the pending latch of the level shown on `lvl_o` is cleared. Without `ack_i`, the shown level is held.
- R9: `ext_ack_o` is high for exactly the cycle after an edge where `ack_i` was high and `lvl_o` equalled 2 plus the routed input number. A route value of 5 or more never pulses.
- R10: A write with `cfg_we_i` stores `cfg_wdata_i` as follows. Address 0 holds the edge-mode mask, where bit k=1 makes input k edge mode. Address 1 holds the polarity mask, where bit k=1 makes input k active low. Address 2 holds the acknowledge route in bits [2:0]. Address 3 is ignored.
- R11: If a new request for a level and an acknowledge of that same level arrive in the same cycle, the level stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 5 | External interrupt pins, asynchronous |
| int_req_i | input | 15 | Internal requests; bit l-1 requests level l |
| ack_i | input | 1 | Processor acknowledge of the shown level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 5 | Configuration write data |
| lvl_o | output | 4 | Encoded highest pending level |
| ext_ack_o | output | 1 | Acknowledge pulse to the routed external source |

## Verification
The bench builds the block with the default values: five external pins placed at levels 2 to 6 and a 4-bit level code. The full 15-level range, the non-maskable code and every external pin are therefore all within reach. Because the route field is three bits wide, the values 5 to 7 can also be driven, so the case where the acknowledge is routed to no input is tested. A behavioural model follows the synchroniser delay, the polarity and mode changes, and coincident set and clear, and is compared against the design on every cycle.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  typedef enum logic [1:0] {
    CFG_EDGE   = 2'd0,
    CFG_POL    = 2'd1,
    CFG_ACKSEL = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_enc_pkg::*;
#(
  parameter int N_EXT = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [N_EXT-1:0] wdata_i,
  output logic [N_EXT-1:0] edge_mode_o,
  output logic [N_EXT-1:0] act_low_o,
  output logic [SEL_W-1:0] ack_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_mode_o <= '0;
      act_low_o   <= '0;
      ack_sel_o   <= '0;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        CFG_EDGE:   edge_mode_o <= wdata_i;
        CFG_POL:    act_low_o   <= wdata_i;
        CFG_ACKSEL: ack_sel_o   <= wdata_i[SEL_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_ext_detect.sv
module irq_ext_detect #(
  parameter int N_EXT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_i,
  input  logic [N_EXT-1:0] edge_mode_i,
  input  logic [N_EXT-1:0] act_low_i,
  output logic [N_EXT-1:0] req_o
);
  for (genvar k = 0; k < N_EXT; k++) begin : g_pin
    logic s1_q, s2_q, act_q;
    logic act;
    assign act = s2_q ^ act_low_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        act_q <= 1'b0;
      end else begin
        s1_q  <= ext_i[k];
        s2_q  <= s1_q;
        act_q <= act;
      end
    end

    assign req_o[k] = edge_mode_i[k] ? (act & ~act_q) : act;
  end
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int N_LVL = 15,
  parameter int LVL_W = 4,
  parameter int N_EXT = 5,
  parameter int SEL_W = 3,
  parameter int EXT_BASE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL:0]   set_i,
  input  logic             ack_i,
  input  logic [SEL_W-1:0] ack_sel_i,
  output logic [N_LVL:0]   pend_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             ext_ack_o
);
  logic [N_LVL:0]   pend_q, pend_d, clr;
  logic [LVL_W-1:0] lvl_q, enc;
  logic             ext_ack_q, route_ok, route_hit;

  always_comb begin
    clr = '0;
    if (ack_i && lvl_q != '0) clr[lvl_q] = 1'b1;
    // set beats clear on the same cycle
    pend_d    = (pend_q & ~clr) | set_i;
    pend_d[0] = 1'b0;
  end

  always_comb begin
    enc = '0;
    for (int l = 1; l <= N_LVL; l++)
      if (pend_q[l]) enc = LVL_W'(l);
  end

  assign route_ok  = {1'b0, ack_sel_i} < (SEL_W+1)'(N_EXT);
  assign route_hit = route_ok && (lvl_q == LVL_W'(EXT_BASE) + LVL_W'(ack_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      lvl_q     <= '0;
      ext_ack_q <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      lvl_q     <= enc;
      ext_ack_q <= ack_i && (lvl_q != '0) && route_hit;
    end
  end

  assign pend_o    = pend_q;
  assign lvl_o     = lvl_q;
  assign ext_ack_o = ext_ack_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_EXT    = 5,
  parameter int LVL_W    = 4,
  parameter int EXT_BASE = 2,
  localparam int N_LVL   = (1 << LVL_W) - 1,
  localparam int SEL_W   = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_LVL-1:0] int_req_i,
  input  logic             ack_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [N_EXT-1:0] cfg_wdata_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             ext_ack_o
);
  logic [N_EXT-1:0] edge_mode, act_low, ext_req;
  logic [SEL_W-1:0] ack_sel;
  logic [N_LVL:0]   set_vec, pend_q;

  irq_cfg_regs #(.N_EXT(N_EXT), .SEL_W(SEL_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .edge_mode_o(edge_mode), .act_low_o(act_low), .ack_sel_o(ack_sel)
  );

  irq_ext_detect #(.N_EXT(N_EXT)) u_det (
    .clk_i, .rst_ni,
    .ext_i(ext_irq_i), .edge_mode_i(edge_mode), .act_low_i(act_low),
    .req_o(ext_req)
  );

  always_comb begin
    set_vec = '0;
    for (int l = 1; l <= N_LVL; l++) set_vec[l] = int_req_i[l-1];
    for (int k = 0; k < N_EXT; k++)
      set_vec[EXT_BASE+k] = set_vec[EXT_BASE+k] | ext_req[k];
  end

  irq_pend_arb #(
    .N_LVL(N_LVL), .LVL_W(LVL_W), .N_EXT(N_EXT),
    .SEL_W(SEL_W), .EXT_BASE(EXT_BASE)
  ) u_arb (
    .clk_i, .rst_ni,
    .set_i(set_vec), .ack_i, .ack_sel_i(ack_sel),
    .pend_o(pend_q), .lvl_o, .ext_ack_o
  );
endmodule

// File: rtl/irq_prio_enc_chk.sv
module irq_prio_enc_chk #(
  parameter int N_LVL = 15,
  parameter int LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic [LVL_W-1:0] lvl_o,
  input logic             ext_ack_o,
  input logic [N_LVL:0]   pend_q,
  input logic [N_LVL:0]   set_vec
);
  a_r2_empty_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q) == '0) |-> (lvl_o == '0));

  a_r2_highest_shown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o != '0) |-> (($past(pend_q) >> lvl_o) == (N_LVL+1)'(1)));

  a_r3_nmi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[N_LVL] |=> (lvl_o == LVL_W'(N_LVL)));

  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && lvl_o != '0 && !set_vec[lvl_o]) |=> !pend_q[$past(lvl_o)]);

  a_r9_pulse_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_ack_o |-> ($past(ack_i) && $past(lvl_o) != '0));
endmodule

bind irq_prio_enc irq_prio_enc_chk #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .lvl_o(lvl_o),
  .ext_ack_o(ext_ack_o), .pend_q(pend_q), .set_vec(set_vec)
);

// File: tb/irq_prio_enc_test.sv
`timescale 1ns/1ps
module irq_prio_enc_test;
  localparam int NE = 5, NL = 15, BASE = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] ext = '0;
  logic [NL-1:0] ireq = '0;
  logic          ack = 1'b0, we = 1'b0;
  logic [1:0]    addr = '0;
  logic [NE-1:0] wdata = '0;
  logic [3:0]    lvl;
  logic          eack;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_prio_enc uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext), .int_req_i(ireq),
    .ack_i(ack), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .lvl_o(lvl), .ext_ack_o(eack)
  );

  // behavioural reference
  bit m_s1[NE], m_s2[NE], m_prev[NE];
  bit m_pend[16];
  int m_lvl, m_sel;
  bit m_ack;
  bit m_edge[NE], m_low[NE];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_s1[k]) begin m_s1[k] = 0; m_s2[k] = 0; m_prev[k] = 0; m_edge[k] = 0; m_low[k] = 0; end
      foreach (m_pend[l]) m_pend[l] = 0;
      m_lvl = 0; m_ack = 0; m_sel = 0;
    end else begin
      bit nxt[16];
      int top;
      top = 0;
      for (int l = 1; l < 16; l++) if (m_pend[l]) top = l;
      nxt = m_pend;
      if (ack && m_lvl != 0) nxt[m_lvl] = 0;
      for (int l = 1; l < 16; l++) if (ireq[l-1]) nxt[l] = 1;
      for (int k = 0; k < NE; k++) begin
        bit a;
        a = m_s2[k] ^ m_low[k];
        if (m_edge[k] ? (a && !m_prev[k]) : a) nxt[BASE+k] = 1;
        m_prev[k] = a;
        m_s2[k] = m_s1[k];
        m_s1[k] = ext[k];
      end
      m_ack = ack && m_lvl != 0 && m_sel < NE && m_lvl == BASE + m_sel;
      m_pend = nxt;
      m_lvl = top;
      if (we) begin
        if (addr == 2'd0) for (int k = 0; k < NE; k++) m_edge[k] = wdata[k];
        if (addr == 2'd1) for (int k = 0; k < NE; k++) m_low[k] = wdata[k];
        if (addr == 2'd2) m_sel = int'(wdata[2:0]);
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (lvl !== 4'(m_lvl)) begin
      fails++; $display("FAIL R2 model lvl_o act=%0d exp=%0d", lvl, m_lvl);
    end
    checks++;
    if (eack !== m_ack) begin
      fails++; $display("FAIL R9 model ext_ack_o act=%0b exp=%0b", eack, m_ack);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_int(int l); ireq[l-1] = 1'b1; step(1); ireq = '0; endtask
  task automatic do_ack; ack = 1'b1; step(1); ack = 1'b0; endtask
  task automatic cfg_wr(int a, int d);
    we = 1'b1; addr = 2'(a); wdata = NE'(d); step(1); we = 1'b0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 lvl in reset", int'(lvl), 0);
    chk("R1 ack in reset", int'(eack), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 lvl after reset", int'(lvl), 0);

    pulse_int(5); step(1);
    chk("R2 internal level shown", int'(lvl), 5);
    pulse_int(15); step(1);
    chk("R3 nmi outranks", int'(lvl), 15);
    do_ack;
    chk("R9 no pulse for nmi", int'(eack), 0);
    step(1);
    chk("R8 next level shown", int'(lvl), 5);
    step(3);
    chk("R8 held without ack", int'(lvl), 5);

    ireq[4] = 1'b1; ack = 1'b1; step(1); ireq = '0; ack = 1'b0; step(1);
    chk("R11 set beats clear", int'(lvl), 5);
    do_ack; step(1);
    chk("R8 cleared", int'(lvl), 0);

    // level mode, input 0 -> level 2
    ext[0] = 1'b1; step(3);
    chk("R4 not before sync", int'(lvl), 0);
    step(1);
    chk("R4 ext level after sync", int'(lvl), 2);
    do_ack;
    chk("R9 routed pulse", int'(eack), 1);
    step(1);
    chk("R9 pulse one cycle", int'(eack), 0);
    chk("R6 level re-asserts", int'(lvl), 2);
    ext[0] = 1'b0; step(4);
    do_ack; step(1);
    chk("R6 cleared once inactive", int'(lvl), 0);

    // edge mode, input 1 -> level 3
    cfg_wr(0, 5'b00010);
    ext[1] = 1'b1; step(4);
    chk("R5 edge sets", int'(lvl), 3);
    do_ack; step(6);
    chk("R5 held pin no reassert", int'(lvl), 0);
    ext[1] = 1'b0; step(4);

    // active low edge, input 2 -> level 4
    cfg_wr(0, 5'b00110);
    cfg_wr(1, 5'b00100);
    step(3); do_ack; step(2);
    chk("R7 cleanup", int'(lvl), 0);
    ext[2] = 1'b1; step(5);
    chk("R7 rising ignored", int'(lvl), 0);
    ext[2] = 1'b0; step(4);
    chk("R7 falling sets", int'(lvl), 4);

    cfg_wr(2, 2);
    do_ack;
    chk("R9 route to input 2", int'(eack), 1);
    step(1);
    chk("R9 pulse ends", int'(eack), 0);
    chk("R5 edge cleared", int'(lvl), 0);

    pulse_int(5); step(1);
    do_ack;
    chk("R9 other level no pulse", int'(eack), 0);
    step(1);

    cfg_wr(3, 5'b11111);
    ext[2] = 1'b1; step(5); ext[2] = 1'b0; step(4);
    chk("R10 addr3 ignored level", int'(lvl), 4);
    do_ack;
    chk("R10 addr3 ignored route", int'(eack), 1);
    step(1);

    cfg_wr(2, 6);
    ext[2] = 1'b1; step(5); ext[2] = 1'b0; step(4);
    chk("R10 route write kept mode", int'(lvl), 4);
    do_ack;
    chk("R9 out of range route", int'(eack), 0);
    step(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule